// File: doc/BRIEF.md
# Diminished-1 Code Conversion Compressor

This block takes two plain binary operands, each 2n bits wide, and turns them into a pair of n-bit words in the diminished-1 number system modulo 2^n+1. The pair stands for either the sum or the difference of the operands, depending on a mode input. It is meant as the entry stage of a Fermat-number-transform datapath. There, the first butterfly addition or subtraction is folded into the binary-to-residue conversion, so the operands never pass through a carry-propagate adder at this point.

Each operand is cut into a high and a low half. Because 2^n is congruent to -1 modulo 2^n+1, the high half has to be subtracted. The block does this by feeding bitwise complements of selected halves into a carry-save 4-2 compressor. The compressor's carries that leave the top bit are inverted and fed back in at bit 0. The result is two words: a sum vector and a rotated carry vector. A later modulo adder combines them; that adder is not part of this block. Both output words are registered.

Top module: `dm1_code_convert`

## Requirements
- R1: A synchronous active-high reset clears both output words to zero on the next rising edge. Outside reset, each output word holds the result of the operands and mode sampled at the previous rising edge, and it does not change between edges.
- R2: With `sub_i` = 0 (add), let M = 2^N+1. Then (sum_o + carry_o + 2) mod M equals (opa_i + opb_i) mod M.
- R3: With `sub_i` = 1 (subtract), (sum_o + carry_o + 2) mod M equals (opa_i - opb_i) mod M.
- R4: With both operands zero, add mode gives sum_o = 1 and carry_o = 2^N-2 (all ones except bit 0), and subtract mode gives sum_o = 2^N-2 and carry_o = 1. Bit 0 of the carry word is the inverted carry out of the top column.
- R5: All 2N operand bits count, with the upper N bits weighted by 2^N. Examples: an operand of 2^N alone gives residue M-1, and operands of all ones (value 2^(2N)-1) give residue 0. R2 and R3 hold at these extremes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | 2*N | First binary operand |
| opb_i | input | 2*N | Second binary operand |
| sub_i | input | 1 | 0 selects A+B, 1 selects A-B |
| sum_o | output | N | Registered diminished-1 sum vector |
| carry_o | output | N | Registered diminished-1 carry vector (rotated, inverted wrap) |

## Verification
With N=4, every operand pair in both modes is applied. This covers every case in which a wrap carry is produced or not in either compressor row, and every complement pattern of the halves. That separates a wrong input routing between the two modes from a wrong wrap inversion. With N=8, random operands show that the scheme scales with the width parameter. Directed all-zero operands pin the exact bit pattern of both words, which a congruence check alone would not distinguish. Operands with only the high half set, or with every bit set, isolate the negative weight of the upper half.

// File: rtl/dm1_pkg.sv
package dm1_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } conv_op_e;
endpackage

// File: rtl/dm1_operand_split.sv
module dm1_operand_split
  import dm1_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0] a_i,
  input  logic [2*N-1:0] b_i,
  input  conv_op_e       op_i,
  output logic [N-1:0]   in0_o,
  output logic [N-1:0]   in1_o,
  output logic [N-1:0]   in2_o,
  output logic [N-1:0]   in3_o
);
  localparam int W = 2*N + 4;
  localparam logic [W-1:0] MOD = (W'(1) << N) + W'(1);

  logic [N-1:0] a_hi, a_lo, b_hi, b_lo;
  assign {a_hi, a_lo} = a_i;
  assign {b_hi, b_lo} = b_i;

  // The high half weighs 2^N, which is -1 mod M; its complement equals -2-hi mod M.
  always_comb begin
    in0_o = a_lo;
    in1_o = ~a_hi;
    if (op_i == OP_ADD) begin
      in2_o = b_lo;
      in3_o = ~b_hi;
    end else begin
      in2_o = ~b_lo;
      in3_o = b_hi;
    end
  end

  logic [W-1:0] total;
  always_comb begin
    total = W'(in0_o) + W'(in1_o) + W'(in2_o) + W'(in3_o) + W'(4);
    if (op_i == OP_ADD) begin
      assert_split_add_R2: assert ((total % MOD) == ((W'(a_i) + W'(b_i)) % MOD));
    end else begin
      assert_split_sub_R3: assert (((total + W'(b_i)) % MOD) == (W'(a_i) % MOD));
    end
  end
endmodule

// File: rtl/dm1_csa_row.sv
module dm1_csa_row #(
  parameter int N = 4
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic [N-1:0] z_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] wrap_o
);
  localparam int W = N + 4;
  localparam logic [W-1:0] MOD = (W'(1) << N) + W'(1);

  logic [N-1:0] cy;

  for (genvar k = 0; k < N; k++) begin : g_col
    assign sum_o[k] = x_i[k] ^ y_i[k] ^ z_i[k];
    assign cy[k]    = (x_i[k] & y_i[k]) | (x_i[k] & z_i[k]) | (y_i[k] & z_i[k]);
  end

  if (N == 1) begin : g_wrap1
    assign wrap_o = ~cy;
  end else begin : g_wrapn
    assign wrap_o = {cy[N-2:0], ~cy[N-1]};
  end

  // Each inverted wrap adds exactly one modulo M to the row total.
  always_comb begin
    assert_row_wrap_R2: assert (((W'(sum_o) + W'(wrap_o)) % MOD) ==
                                ((W'(x_i) + W'(y_i) + W'(z_i) + W'(1)) % MOD));
  end
endmodule

// File: rtl/dm1_compress42.sv
module dm1_compress42 #(
  parameter int N = 4
) (
  input  logic [N-1:0] in0_i,
  input  logic [N-1:0] in1_i,
  input  logic [N-1:0] in2_i,
  input  logic [N-1:0] in3_i,
  output logic [N-1:0] h0_o,
  output logic [N-1:0] h1_o
);
  localparam int W = N + 4;
  localparam logic [W-1:0] MOD = (W'(1) << N) + W'(1);

  logic [N-1:0] s_mid, w_mid;

  dm1_csa_row #(.N(N)) u_row0 (
    .x_i   (in0_i),
    .y_i   (in1_i),
    .z_i   (in2_i),
    .sum_o (s_mid),
    .wrap_o(w_mid)
  );

  dm1_csa_row #(.N(N)) u_row1 (
    .x_i   (s_mid),
    .y_i   (in3_i),
    .z_i   (w_mid),
    .sum_o (h0_o),
    .wrap_o(h1_o)
  );

  // Two wrap stages together add two modulo M; serves both modes (R2, R3).
  always_comb begin
    assert_compress_total_R3: assert (((W'(h0_o) + W'(h1_o)) % MOD) ==
      ((W'(in0_i) + W'(in1_i) + W'(in2_i) + W'(in3_i) + W'(2)) % MOD));
  end
endmodule

// File: rtl/dm1_code_convert.sv
module dm1_code_convert
  import dm1_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] opa_i,
  input  logic [2*N-1:0] opb_i,
  input  logic           sub_i,
  output logic [N-1:0]   sum_o,
  output logic [N-1:0]   carry_o
);
  conv_op_e     op;
  logic [N-1:0] c0, c1, c2, c3;
  logic [N-1:0] h0, h1;

  assign op = sub_i ? OP_SUB : OP_ADD;

  dm1_operand_split #(.N(N)) u_split (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .op_i (op),
    .in0_o(c0),
    .in1_o(c1),
    .in2_o(c2),
    .in3_o(c3)
  );

  dm1_compress42 #(.N(N)) u_comp (
    .in0_i(c0),
    .in1_i(c1),
    .in2_i(c2),
    .in3_i(c3),
    .h0_o (h0),
    .h1_o (h1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= '0;
    end else begin
      sum_o   <= h0;
      carry_o <= h1;
    end
  end

  localparam logic [N-1:0] LOW_ONE  = N'(1);
  localparam logic [N-1:0] ALL_BUT0 = ~N'(1);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_o == '0 && carry_o == '0));

  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sum_o == $past(h0) && carry_o == $past(h1)));

  assert_zero_add_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && opa_i == '0 && opb_i == '0 && !sub_i)
      |-> (sum_o == LOW_ONE && carry_o == ALL_BUT0));

  assert_zero_sub_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && opa_i == '0 && opb_i == '0 && sub_i)
      |-> (sum_o == ALL_BUT0 && carry_o == LOW_ONE));
endmodule

// File: tb/dm1_code_convert_test.sv
module dm1_code_convert_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0]  a4 = '0, b4 = '0;
  logic        s4 = 1'b0;
  logic [3:0]  sum4, car4;
  logic [15:0] a8 = '0, b8 = '0;
  logic        s8 = 1'b0;
  logic [7:0]  sum8, car8;

  int checks = 0;
  int fails  = 0;

  dm1_code_convert #(.N(4)) uut (
    .clk(clk), .rst(rst), .opa_i(a4), .opb_i(b4), .sub_i(s4),
    .sum_o(sum4), .carry_o(car4)
  );

  dm1_code_convert #(.N(8)) uut_w (
    .clk(clk), .rst(rst), .opa_i(a8), .opb_i(b8), .sub_i(s8),
    .sum_o(sum8), .carry_o(car8)
  );

  task automatic eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input int n, input longint a, input longint b,
                         input bit sub, input longint h0, input longint h1);
    longint m, exp, act;
    m   = (longint'(1) << n) + 1;
    act = (h0 + h1 + 2) % m;
    if (sub) exp = ((a % m) + m - (b % m)) % m;
    else     exp = (a + b) % m;
    eq(req, act, exp);
  endtask

  task automatic drive4(input logic [7:0] a, input logic [7:0] b, input logic s);
    @(negedge clk);
    a4 = a; b4 = b; s4 = s;
    @(posedge clk);
    #1;
  endtask

  task automatic drive8(input logic [15:0] a, input logic [15:0] b, input logic s);
    @(negedge clk);
    a8 = a; b8 = b; s8 = s;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    eq("R1 reset sum4", sum4, 0);
    eq("R1 reset car4", car4, 0);
    eq("R1 reset sum8", sum8, 0);
    eq("R1 reset car8", car8, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    logic [3:0] ps, pc;
    drive4(8'h37, 8'hA5, 1'b0);
    chk_res("R1 after edge", 4, 8'h37, 8'hA5, 1'b0, sum4, car4);
    ps = sum4; pc = car4;
    @(negedge clk);
    a4 = 8'hF0; b4 = 8'h0F; s4 = 1'b1;
    #1;
    eq("R1 hold sum", sum4, ps);
    eq("R1 hold car", car4, pc);
    @(posedge clk);
    #1;
    chk_res("R1 next edge", 4, 8'hF0, 8'h0F, 1'b1, sum4, car4);
  endtask

  task automatic t_zero;
    drive4(8'h00, 8'h00, 1'b0);
    eq("R4 add sum4", sum4, 1);
    eq("R4 add car4", car4, 14);
    drive4(8'h00, 8'h00, 1'b1);
    eq("R4 sub sum4", sum4, 14);
    eq("R4 sub car4", car4, 1);
    drive8(16'h0000, 16'h0000, 1'b0);
    eq("R4 add sum8", sum8, 1);
    eq("R4 add car8", car8, 254);
    drive8(16'h0000, 16'h0000, 1'b1);
    eq("R4 sub sum8", sum8, 254);
    eq("R4 sub car8", car8, 1);
  endtask

  task automatic t_wide;
    drive4(8'h10, 8'h00, 1'b0);
    eq("R5 high half weight", (longint'(sum4) + car4 + 2) % 17, 16);
    drive4(8'hFF, 8'hFF, 1'b0);
    chk_res("R5 ones add", 4, 8'hFF, 8'hFF, 1'b0, sum4, car4);
    drive4(8'hFF, 8'h01, 1'b1);
    chk_res("R5 ones sub", 4, 8'hFF, 8'h01, 1'b1, sum4, car4);
    drive8(16'h0100, 16'h0000, 1'b0);
    eq("R5 high half weight n8", (longint'(sum8) + car8 + 2) % 257, 256);
    drive8(16'hFFFF, 16'h8000, 1'b1);
    chk_res("R5 wide sub n8", 8, 16'hFFFF, 16'h8000, 1'b1, sum8, car8);
  endtask

  task automatic t_sweep4;
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          drive4(a[7:0], b[7:0], s[0]);
          chk_res(s == 0 ? "R2 sweep n4" : "R3 sweep n4", 4, a, b, s[0], sum4, car4);
        end
      end
    end
  endtask

  task automatic t_random8;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb;
      logic        rs;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rs = 1'($urandom);
      drive8(ra, rb, rs);
      chk_res(rs ? "R3 random n8" : "R2 random n8", 8, ra, rb, rs, sum8, car8);
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_zero();
    t_wide();
    t_sweep4();
    t_random8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule